// File: doc/BRIEF.md
# Release-on-acknowledge bus interrupter

This block raises a prioritized interrupt request on a VME-style backplane on behalf of a local device. A configuration input selects one of seven request levels, and a byte-wide configuration input gives the status/ID vector. While the local interrupt input is high and the block is armed, the request line for the selected level is driven. The backplane acknowledge daisy chain reaches the block through `iackin_n`. If the cycle acknowledges the block's own level and a request is pending, the block puts the vector on the low data byte and then asserts DTACK. In every other case it passes the acknowledge on through `iackout_n`.

The request is released when the acknowledge data strobe ends, which is release-on-acknowledge behaviour. The request stays down after that, even if the local interrupt input is still high. A fresh request needs the local input to fall and then rise again. All bus inputs are sampled on `clk`, and all outputs come from registers. Reset is synchronous and active high.

Top module: `vme_roak_irq`

## Requirements
- R1: In reset and on the first clock after it, `irq_drive` is all zero, `iackout_n` and `dtack_n` are 1, and `vec_oe` is 0.
- R2: When `local_int` is high and the block is armed, one clock later `irq_drive` has exactly one bit set, bit (`cfg_level`-1). A change of `cfg_level` moves that bit one clock later.
- R3: A `cfg_level` of 0 drives no request line, and every acknowledge cycle is passed down the chain.
- R4: A cycle is qualified when `iack_n`, `as_n` and `iackin_n` are low and `as_n` was also low on the previous clock. If it is qualified, `ds0_n` is low, a request is pending and `ack_level` equals `cfg_level`, then on the next clock `vec_oe` is 1 and `vec_data` equals `cfg_vector`. `dtack_n` goes low one clock after that.
- R5: A qualified cycle whose `ack_level` differs from `cfg_level` drives `iackout_n` low on the next clock. It drives no vector and no DTACK, and the pending request stays on its line.
- R6: A qualified cycle that arrives while no request is pending is passed through `iackout_n`, whatever the level.
- R7: `iackout_n` never falls while `iackin_n` is high. It also never falls on the first clock that samples `as_n` low.
- R8: `iackout_n` returns to 1 on the clock after `as_n` is sampled high.
- R9: While DTACK is driven, a clock that samples `ds0_n` high releases `vec_oe`, `dtack_n` and the request line, all on the same edge.
- R10: After a release, the request stays off while `local_int` remains high. It is raised again only after `local_int` has been sampled low and then high.
- R11: With `iack_n` high, strobes and `iackin_n` cause no vector, no DTACK and no `iackout_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| local_int | input | 1 | Local interrupt, active high |
| cfg_level | input | 3 | Request level 1..7, 0 disables |
| cfg_vector | input | 8 | Status/ID byte returned on acknowledge |
| iack_n | input | 1 | Acknowledge-cycle marker, active low |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Low data strobe, active low |
| iackin_n | input | 1 | Daisy-chain input, active low |
| ack_level | input | 3 | Level being acknowledged (address bits 3..1) |
| irq_drive | output | 7 | Request line enables, bit k drives level k+1 |
| iackout_n | output | 1 | Daisy-chain output, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| vec_oe | output | 1 | Enable for driving the vector onto the data byte |
| vec_data | output | 8 | Vector byte |

## Verification
The bench builds the block with its defaults: seven levels, a 3-bit level code and an 8-bit vector. With these values every request line, level 0 as the disable code, and a mismatching level code can all be reached on one instance. Level 3 and then level 6 are exercised as the block's own level. Acknowledges at levels 5 and 0 cover the mismatch and disabled cases. A single-sample address strobe, a late chain input and a non-acknowledge cycle carrying a matching level cover the qualification corners.

// File: rtl/vme_roak_pkg.sv
package vme_roak_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_ACK,
    ST_PASS,
    ST_HOLD
  } resp_st_t;
endpackage

// File: rtl/vme_roak_req.sv
// Request tracker: arms on low local input, raises on high, drops on release.
module vme_roak_req #(
  parameter int NLVL  = 7,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             local_int,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             release_req,
  output logic             pending,
  output logic [NLVL-1:0]  irq_drive
);
  logic armed;
  logic pend_nxt;
  logic armed_nxt;
  logic [NLVL-1:0] line_nxt;

  always_comb begin
    pend_nxt  = pending;
    armed_nxt = armed;
    if (release_req) begin
      pend_nxt  = 1'b0;
      armed_nxt = 1'b0;
    end else begin
      if (local_int && armed) pend_nxt = 1'b1;
      if (!local_int)         armed_nxt = 1'b1;
    end
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_line
    assign line_nxt[g] = pend_nxt && (cfg_level == LVL_W'(g + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      armed     <= 1'b1;
      irq_drive <= '0;
    end else begin
      pending   <= pend_nxt;
      armed     <= armed_nxt;
      irq_drive <= line_nxt;
    end
  end
endmodule

// File: rtl/vme_roak_resp.sv
// Acknowledge-cycle responder and daisy-chain pass logic.
module vme_roak_resp
  import vme_roak_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic [VEC_W-1:0] cfg_vector,
  input  logic             iack_n,
  input  logic             as_n,
  input  logic             ds0_n,
  input  logic             iackin_n,
  input  logic [LVL_W-1:0] ack_level,
  output logic             release_req,
  output logic             iackout_n,
  output logic             dtack_n,
  output logic             vec_oe,
  output logic [VEC_W-1:0] vec_data
);
  resp_st_t st;
  logic     as_seen;
  logic     qualify;
  logic     ours;

  assign qualify = !iack_n && !as_n && as_seen && !iackin_n;
  assign ours    = pending && (ack_level == cfg_level) && (cfg_level != '0);
  assign release_req = (st == ST_ACK) && (ds0_n || as_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      as_seen   <= 1'b0;
      iackout_n <= 1'b1;
      dtack_n   <= 1'b1;
      vec_oe    <= 1'b0;
      vec_data  <= '0;
    end else begin
      as_seen <= !as_n;
      case (st)
        ST_IDLE: begin
          if (qualify) begin
            if (!ours) begin
              iackout_n <= 1'b0;
              st        <= ST_PASS;
            end else if (!ds0_n) begin
              vec_oe   <= 1'b1;
              vec_data <= cfg_vector;
              st       <= ST_DRIVE;
            end
          end
        end
        ST_DRIVE: begin
          if (as_n) begin
            vec_oe <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            dtack_n <= 1'b0;
            st      <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (ds0_n || as_n) begin
            vec_oe  <= 1'b0;
            dtack_n <= 1'b1;
            st      <= as_n ? ST_IDLE : ST_HOLD;
          end
        end
        ST_PASS: begin
          if (as_n) begin
            iackout_n <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (as_n) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vme_roak_irq.sv
module vme_roak_irq #(
  parameter int NLVL  = 7,
  parameter int VEC_W = 8,
  localparam int LVL_W = $clog2(NLVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             local_int,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic [VEC_W-1:0] cfg_vector,
  input  logic             iack_n,
  input  logic             as_n,
  input  logic             ds0_n,
  input  logic             iackin_n,
  input  logic [LVL_W-1:0] ack_level,
  output logic [NLVL-1:0]  irq_drive,
  output logic             iackout_n,
  output logic             dtack_n,
  output logic             vec_oe,
  output logic [VEC_W-1:0] vec_data
);
  logic pending;
  logic release_req;

  vme_roak_req #(.NLVL(NLVL), .LVL_W(LVL_W)) u_req (
    .clk(clk), .rst(rst), .local_int(local_int), .cfg_level(cfg_level),
    .release_req(release_req), .pending(pending), .irq_drive(irq_drive)
  );

  vme_roak_resp #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_resp (
    .clk(clk), .rst(rst), .pending(pending), .cfg_level(cfg_level),
    .cfg_vector(cfg_vector), .iack_n(iack_n), .as_n(as_n), .ds0_n(ds0_n),
    .iackin_n(iackin_n), .ack_level(ack_level), .release_req(release_req),
    .iackout_n(iackout_n), .dtack_n(dtack_n), .vec_oe(vec_oe),
    .vec_data(vec_data)
  );
endmodule

// File: rtl/vme_roak_irq_chk.sv
module vme_roak_irq_chk #(
  parameter int NLVL = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            local_int,
  input logic            iack_n,
  input logic            as_n,
  input logic            ds0_n,
  input logic            iackin_n,
  input logic [NLVL-1:0] irq_drive,
  input logic            iackout_n,
  input logic            dtack_n,
  input logic            vec_oe
);
  p_one_line_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_drive));

  p_dtack_with_vec_r4: assert property (@(posedge clk) disable iff (rst)
    !dtack_n |-> vec_oe);

  p_pass_excl_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !(!iackout_n && vec_oe));

  p_chain_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(iackout_n) |-> $past(!iackin_n && !as_n && !iack_n));

  p_pass_ends_r8: assert property (@(posedge clk) disable iff (rst)
    as_n |=> iackout_n);

  p_strobe_release_r9: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && ds0_n) |=> (dtack_n && !vec_oe));

  p_roak_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && ds0_n && local_int) |=> (irq_drive == '0));
endmodule

bind vme_roak_irq vme_roak_irq_chk #(.NLVL(NLVL)) u_chk (
  .clk(clk), .rst(rst), .local_int(local_int), .iack_n(iack_n),
  .as_n(as_n), .ds0_n(ds0_n), .iackin_n(iackin_n), .irq_drive(irq_drive),
  .iackout_n(iackout_n), .dtack_n(dtack_n), .vec_oe(vec_oe)
);

// File: tb/vme_roak_irq_bench.sv
module vme_roak_irq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       local_int = 1'b0;
  logic [2:0] cfg_level = 3'd3;
  logic [7:0] cfg_vector = 8'hA5;
  logic       iack_n = 1'b1, as_n = 1'b1, ds0_n = 1'b1, iackin_n = 1'b1;
  logic [2:0] ack_level = 3'd0;
  logic [6:0] irq_drive;
  logic       iackout_n, dtack_n, vec_oe;
  logic [7:0] vec_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vme_roak_irq u_vme_roak_irq (
    .clk(clk), .rst(rst), .local_int(local_int), .cfg_level(cfg_level),
    .cfg_vector(cfg_vector), .iack_n(iack_n), .as_n(as_n), .ds0_n(ds0_n),
    .iackin_n(iackin_n), .ack_level(ack_level), .irq_drive(irq_drive),
    .iackout_n(iackout_n), .dtack_n(dtack_n), .vec_oe(vec_oe),
    .vec_data(vec_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int         m_phase;   // 0 idle, 1 vector out, 2 acked, 3 passing, 4 wait strobe end
  bit         m_pend, m_armed, m_seen, m_rel, m_q, m_own;
  logic [6:0] m_irq;
  bit         m_iackout, m_dtack, m_oe;
  logic [7:0] m_vec;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_pend = 0; m_armed = 1; m_seen = 0; m_irq = '0;
      m_iackout = 1; m_dtack = 1; m_oe = 0; m_vec = '0;
    end else begin
      m_rel = 0;
      m_q   = !iack_n && !as_n && m_seen && !iackin_n;
      m_own = m_pend && ack_level == cfg_level && cfg_level != 0;
      if (m_phase == 0) begin
        if (m_q && !m_own) begin m_iackout = 0; m_phase = 3; end
        else if (m_q && !ds0_n) begin m_oe = 1; m_vec = cfg_vector; m_phase = 1; end
      end else if (m_phase == 1) begin
        if (as_n) begin m_oe = 0; m_phase = 0; end
        else begin m_dtack = 0; m_phase = 2; end
      end else if (m_phase == 2) begin
        if (ds0_n || as_n) begin
          m_oe = 0; m_dtack = 1; m_rel = 1; m_phase = as_n ? 0 : 4;
        end
      end else if (m_phase == 3) begin
        if (as_n) begin m_iackout = 1; m_phase = 0; end
      end else if (as_n) m_phase = 0;
      if (m_rel) begin m_pend = 0; m_armed = 0; end
      else begin
        if (local_int && m_armed) m_pend = 1;
        if (!local_int) m_armed = 1;
      end
      m_irq = '0;
      if (m_pend && cfg_level != 0) m_irq[cfg_level-1] = 1'b1;
      m_seen = !as_n;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model irq_drive", 32'(irq_drive), 32'(m_irq));
      chk("R7 model iackout_n", 32'(iackout_n), 32'(m_iackout));
      chk("R4 model dtack_n", 32'(dtack_n), 32'(m_dtack));
      chk("R4 model vec_oe", 32'(vec_oe), 32'(m_oe));
      if (m_oe) chk("R4 model vec_data", 32'(vec_data), 32'(m_vec));
    end
  end

  // One acknowledge cycle at level lvl; own selects vector or pass expectation.
  task automatic ack(input logic [2:0] lvl, input bit own, input string tag,
                     input logic [6:0] irq_after);
    @(negedge clk); iack_n = 0; ack_level = lvl; as_n = 0;
    @(negedge clk); iackin_n = 0; ds0_n = 0;
    @(negedge clk);
    if (own) begin
      chk("R4 vector enable", 32'(vec_oe), 1);
      chk("R4 vector byte", 32'(vec_data), 32'(cfg_vector));
      chk("R4 no pass when own", 32'(iackout_n), 1);
    end else begin
      chk({tag, " pass low"}, 32'(iackout_n), 0);
      chk({tag, " no vector"}, 32'(vec_oe), 0);
    end
    @(negedge clk);
    chk(own ? "R4 dtack low" : {tag, " no dtack"}, 32'(dtack_n), own ? 0 : 1);
    ds0_n = 1;
    @(negedge clk);
    if (own) begin
      chk("R9 vector released", 32'(vec_oe), 0);
      chk("R9 dtack released", 32'(dtack_n), 1);
      chk("R9 irq released", 32'(irq_drive), 0);
    end else chk({tag, " pass held"}, 32'(iackout_n), 0);
    as_n = 1; iackin_n = 1; iack_n = 1;
    @(negedge clk);
    chk("R8 iackout released", 32'(iackout_n), 1);
    chk({tag, " irq after cycle"}, 32'(irq_drive), 32'(irq_after));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq_drive), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq_drive), 0);
    chk("R1 iackout after reset", 32'(iackout_n), 1);
    chk("R1 dtack after reset", 32'(dtack_n), 1);
    chk("R1 vec_oe after reset", 32'(vec_oe), 0);

    // R2: request on level 3 -> bit 2
    local_int = 1;
    @(negedge clk);
    chk("R2 level3 line", 32'(irq_drive), 32'h04);

    // R5: mismatch at level 5 passes, request stays
    ack(3'd5, 0, "R5", 7'h04);

    // R4/R9: own acknowledge, then R10 stays off
    ack(3'd3, 1, "R4", 7'h00);
    repeat (3) @(negedge clk);
    chk("R10 stays off while int high", 32'(irq_drive), 0);

    // R6: no pending -> pass even at own level
    ack(3'd3, 0, "R6", 7'h00);

    // R10: low then high rearms
    local_int = 0;
    @(negedge clk);
    chk("R10 still off after low", 32'(irq_drive), 0);
    local_int = 1;
    @(negedge clk);
    chk("R10 re-request", 32'(irq_drive), 32'h04);

    // R2: level move
    cfg_level = 3'd6; cfg_vector = 8'h3C;
    @(negedge clk);
    chk("R2 level6 line", 32'(irq_drive), 32'h20);

    // R11: not an acknowledge cycle
    iack_n = 1; as_n = 0; ds0_n = 0; iackin_n = 0; ack_level = 3'd6;
    repeat (3) begin
      @(negedge clk);
      chk("R11 no pass", 32'(iackout_n), 1);
      chk("R11 no vector", 32'(vec_oe), 0);
      chk("R11 no dtack", 32'(dtack_n), 1);
    end
    as_n = 1; ds0_n = 1; iackin_n = 1;
    @(negedge clk);
    chk("R11 request kept", 32'(irq_drive), 32'h20);

    // R7: chain input late
    iack_n = 0; as_n = 0; ds0_n = 0; ack_level = 3'd6;
    repeat (3) begin
      @(negedge clk);
      chk("R7 no response without iackin", 32'(vec_oe), 0);
      chk("R7 no pass without iackin", 32'(iackout_n), 1);
    end
    iackin_n = 0;
    @(negedge clk);
    chk("R7 late iackin own vector", 32'(vec_oe), 1);
    chk("R4 vector level6", 32'(vec_data), 32'h3C);
    @(negedge clk);
    chk("R4 dtack level6", 32'(dtack_n), 0);
    ds0_n = 1;
    @(negedge clk);
    chk("R9 release level6", 32'(irq_drive), 0);
    as_n = 1; iackin_n = 1; iack_n = 1;
    @(negedge clk);

    // R7: address strobe seen once only -> no pass yet
    iack_n = 0; as_n = 0; iackin_n = 0; ack_level = 3'd2;
    @(negedge clk);
    chk("R7 single AS sample no pass", 32'(iackout_n), 1);
    @(negedge clk);
    chk("R7 delayed AS pass", 32'(iackout_n), 0);
    as_n = 1; iackin_n = 1; iack_n = 1;
    @(negedge clk);
    chk("R8 pass released", 32'(iackout_n), 1);

    // R3: level 0 disables lines and passes
    local_int = 0;
    @(negedge clk);
    local_int = 1; cfg_level = 3'd0;
    @(negedge clk);
    chk("R3 no line at level0", 32'(irq_drive), 0);
    ack(3'd0, 0, "R3", 7'h00);
    cfg_level = 3'd1;
    @(negedge clk);
    chk("R2 level1 line", 32'(irq_drive), 32'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule